// File: doc/BRIEF.md
# DDS Register-Write Command Sequencer

This block sits between a controller that wants to change a DDS channel's output and the chip's 16-bit parallel control bus. It takes one command at a time over a valid/ready handshake and turns it into a fixed series of address/data writes. Each write owns a slot of a fixed number of clock cycles. There are three kinds of command. A standard set writes the 32-bit tuning word, a control word picked by the phase mode, a corrected phase word and an amplitude, and then fires a frequency-update strobe. An extended set spreads a 63-bit tuning word over the ramp-limit and frequency registers. An extended exit clears the ramp-limit registers.

For a standard set, the block adjusts the requested phase word so that the DDS phase agrees with a reference timestamp supplied with the command. This keeps the phase relationship between channels well defined when they are updated at different moments. In tracking mode the block also adds the phase the channel would have built up if it had run at the new frequency since time zero. The block returns the 16-bit phase word it wrote. When the last write of a command completes, it pulses a done flag.

Top module: `dds_cmd_seq`

## Requirements
- R1: Each bus write occupies exactly WRITE_CYC (default 5) clock cycles. `bus_wr` is high only in the first cycle of a slot, `bus_addr`/`bus_data` stay constant for the whole slot, and the next slot's strobe comes exactly WRITE_CYC cycles after the previous one. The first strobe appears in the cycle right after acceptance.
- R2: A standard set (`cmd_op` = 0) issues 7 writes to these addresses in this order: 0x81, 0x11, 0x13, 0x01, 0x31, 0x33, 0x80. The data for 0x11 is ftw[15:0], for 0x13 is ftw[31:16], and for 0x33 is the amplitude zero-extended to 16 bits.
- R3: Every command opens with a channel-select write to 0x81 with data `16'h0002 << cmd_chan`. The update strobe write goes to 0x80 with data 0.
- R4: In a standard set, the write to 0x01 carries 0x0108 when `cmd_mode` = 0 (continuous) and 0x2108 for `cmd_mode` 1, 2 or 3 (accumulator cleared on update).
- R5: The word written to 0x31 equals `cmd_pow − P[31:16]` modulo 2^16. Here P = (ref − upd)·SYS_PER_MU·ftw truncated to 64 bits, upd = start + 6·WRITE_MU, and only the low 32 bits of `cmd_start` and `cmd_ref` take part.
- R6: When `cmd_mode` = 2 (tracking), the block also adds T[31:16] to the phase word, where T = ref·SYS_PER_MU·ftw truncated to 64 bits.
- R7: An extended set (`cmd_op` = 1) issues 7 writes: 0x81 select, 0x19 ← x[15:0], 0x1b ← {0, x[30:16]}, 0x11 ← x[46:31], 0x13 ← x[62:47], 0x33 ← amplitude, 0x80 ← 0.
- R8: An extended exit (`cmd_op` = 2 or 3) issues 3 writes: 0x81 select, 0x19 ← 0, 0x1b ← 0.
- R9: `cmd_ready` is low from acceptance until the command ends. A command presented while the block is busy waits with no loss and is accepted in the cycle in which `done` is high, so its first strobe comes WRITE_CYC+1 cycles after the previous command's last strobe.
- R10: `done` is high for exactly one cycle, WRITE_CYC cycles after the last strobe of a command. `res_pow` is loaded at that point with the phase word of a standard set. Extended set and exit leave it unchanged.
- R11: After reset, `cmd_ready` is 1 and `busy`, `done`, `bus_wr` and `res_pow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 standard set, 1 extended set, 2/3 extended exit |
| cmd_chan | input | CH_W | Channel index on the bus |
| cmd_ftw | input | 32 | Frequency tuning word |
| cmd_xftw | input | 63 | Extended tuning word |
| cmd_pow | input | 16 | Requested phase word |
| cmd_asf | input | 12 | Amplitude scale |
| cmd_mode | input | 2 | 0 continuous, 1 absolute, 2 tracking, 3 as absolute |
| cmd_start | input | 32 | Timestamp of the first write |
| cmd_ref | input | 32 | Phase reference timestamp |
| bus_wr | output | 1 | Write strobe, first cycle of each slot |
| bus_addr | output | 8 | Register address |
| bus_data | output | 16 | Register data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| res_pow | output | 16 | Phase word written by the latest standard set |

## Verification
The hardest case to reach is a second command that arrives while the first is still running. The block must hold it off and must not let it corrupt the first command's latched fields. It must then accept it in exactly the cycle done is high. The bench reaches this by presenting the second command with different field values as soon as the first is taken, and then checks both write streams and the one-cycle gap between them. The phase arithmetic is driven from timestamps near 2^36 and 2^39. Some are placed before the update time so that the difference is negative, which tests that the 32-bit shortcut agrees with the 64-bit expected value. The sweep covers every channel and every phase mode.

// File: rtl/dds_seq_pkg.sv
// Package: shared constants and the latched-command type for the DDS
// write sequencer. Addresses are the ones the DDS decodes.
package dds_seq_pkg;
    localparam int STEP_W    = 3;
    localparam int N_LONG    = 7;   // writes in a set or extended set
    localparam int N_EXIT    = 3;   // writes in an extended exit
    localparam int UPD_SLOTS = 6;   // slots before the update strobe

    localparam logic [7:0] ADDR_SELECT    = 8'h81;
    localparam logic [7:0] ADDR_UPDATE    = 8'h80;
    localparam logic [7:0] ADDR_FREQ_LO   = 8'h11;
    localparam logic [7:0] ADDR_FREQ_HI   = 8'h13;
    localparam logic [7:0] ADDR_CTRL_LO   = 8'h01;
    localparam logic [7:0] ADDR_PHASE     = 8'h31;
    localparam logic [7:0] ADDR_AMPL      = 8'h33;
    localparam logic [7:0] ADDR_RAMP_A_LO = 8'h19;
    localparam logic [7:0] ADDR_RAMP_A_HI = 8'h1b;

    localparam logic [15:0] CTRL_KEEP_ACC  = 16'h0108;
    localparam logic [15:0] CTRL_CLEAR_ACC = 16'h2108;

    localparam logic [1:0] OP_SET   = 2'd0;
    localparam logic [1:0] OP_XSET  = 2'd1;
    localparam logic [1:0] MODE_CONT  = 2'd0;
    localparam logic [1:0] MODE_TRACK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  mode;
        logic [31:0] ftw;
        logic [62:0] xftw;
        logic [15:0] pow;
        logic [11:0] asf;
        logic [31:0] t_start;
        logic [31:0] t_ref;
    } cmd_t;
endpackage

// File: rtl/dds_write_timer.sv
// Module: slot timer. Steps through num_writes slots of WRITE_CYC cycles
// each after a launch pulse. Assumes launch only arrives while idle and
// num_writes stays constant while active.
module dds_write_timer #(
    parameter int WRITE_CYC = 5,
    parameter int STEP_W    = 3,
    localparam int CNT_W    = (WRITE_CYC > 2) ? $clog2(WRITE_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [STEP_W-1:0] num_writes,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output logic              strobe,
    output logic              finish
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             slot_end;
    logic             last_step;

    // Slot end and last-step decode.
    always_comb begin
        slot_end  = active && (cnt == LAST_CNT);
        last_step = (step == num_writes - STEP_W'(1));
        strobe    = active && (cnt == '0);
        finish    = slot_end && last_step;
    end

    // Advance the cycle counter and the step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
            cnt    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            step   <= '0;
            cnt    <= '0;
        end else if (slot_end) begin
            cnt <= '0;
            if (last_step) active <= 1'b0;
            else           step   <= step + STEP_W'(1);
        end else if (active) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dds_phase_comp.sv
// Module: phase-word compensation. Purely combinational. Only bits [31:16]
// of each 64-bit product reach the result, so all arithmetic is done
// modulo 2^32 on the low halves of the timestamps.
module dds_phase_comp
    import dds_seq_pkg::*;
#(
    parameter int SYS_PER_MU = 3,
    parameter int WRITE_MU   = 40
) (
    input  logic [31:0] ftw,
    input  logic [15:0] pow_in,
    input  logic [1:0]  mode,
    input  logic [31:0] t_start,
    input  logic [31:0] t_ref,
    output logic [15:0] pow_out
);
    localparam logic [31:0] K_MUL   = 32'(SYS_PER_MU);
    localparam logic [31:0] UPD_OFS = 32'(UPD_SLOTS * WRITE_MU);

    logic [31:0] t_upd, t_diff, p_diff, p_track;
    logic [15:0] track_term;

    // Update time, offset product and absolute product.
    always_comb begin
        t_upd   = t_start + UPD_OFS;
        t_diff  = t_ref - t_upd;
        p_diff  = t_diff * K_MUL * ftw;
        p_track = t_ref * K_MUL * ftw;
    end

    // Tracking term only in tracking mode; wrap to 16 bits.
    always_comb begin
        track_term = (mode == MODE_TRACK) ? p_track[31:16] : 16'h0000;
        pow_out    = pow_in - p_diff[31:16] + track_term;
    end
endmodule

// File: rtl/dds_seq_decode.sv
// Module: maps (opcode, step) to the bus address and data of that write
// and gives the write count of the command. Combinational.
module dds_seq_decode
    import dds_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic [1:0]        op,
    input  logic [1:0]        mode,
    input  logic [CH_W-1:0]   chan,
    input  logic [31:0]       ftw,
    input  logic [62:0]       xftw,
    input  logic [15:0]       pow_word,
    input  logic [11:0]       asf,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] num_writes,
    output logic [7:0]        addr,
    output logic [15:0]       data
);
    logic [15:0] sel_word;
    logic [15:0] ctrl_word;

    // Channel one-hot shifted up by one, and control word by mode.
    always_comb begin
        sel_word  = 16'h0002 << chan;
        ctrl_word = (mode == MODE_CONT) ? CTRL_KEEP_ACC : CTRL_CLEAR_ACC;
    end

    // Step decode per command kind.
    always_comb begin
        addr = ADDR_UPDATE;
        data = 16'h0000;
        if (op[1]) begin
            num_writes = STEP_W'(N_EXIT);
            case (step)
                3'd0:    begin addr = ADDR_SELECT;    data = sel_word; end
                3'd1:    begin addr = ADDR_RAMP_A_LO; data = 16'h0000; end
                default: begin addr = ADDR_RAMP_A_HI; data = 16'h0000; end
            endcase
        end else if (op == OP_XSET) begin
            num_writes = STEP_W'(N_LONG);
            case (step)
                3'd0:    begin addr = ADDR_SELECT;    data = sel_word; end
                3'd1:    begin addr = ADDR_RAMP_A_LO; data = xftw[15:0]; end
                3'd2:    begin addr = ADDR_RAMP_A_HI; data = {1'b0, xftw[30:16]}; end
                3'd3:    begin addr = ADDR_FREQ_LO;   data = xftw[46:31]; end
                3'd4:    begin addr = ADDR_FREQ_HI;   data = xftw[62:47]; end
                3'd5:    begin addr = ADDR_AMPL;      data = {4'h0, asf}; end
                default: begin addr = ADDR_UPDATE;    data = 16'h0000; end
            endcase
        end else begin
            num_writes = STEP_W'(N_LONG);
            case (step)
                3'd0:    begin addr = ADDR_SELECT;  data = sel_word; end
                3'd1:    begin addr = ADDR_FREQ_LO; data = ftw[15:0]; end
                3'd2:    begin addr = ADDR_FREQ_HI; data = ftw[31:16]; end
                3'd3:    begin addr = ADDR_CTRL_LO; data = ctrl_word; end
                3'd4:    begin addr = ADDR_PHASE;   data = pow_word; end
                3'd5:    begin addr = ADDR_AMPL;    data = {4'h0, asf}; end
                default: begin addr = ADDR_UPDATE;  data = 16'h0000; end
            endcase
        end
    end
endmodule

// File: rtl/dds_cmd_seq.sv
// Module: top of the DDS write sequencer. Latches one command on a
// valid/ready handshake, runs its write sequence through the slot timer,
// and reports done and the phase word of standard sets. Assumes the
// channel count fits the 16-bit select word (NUM_CH <= 15).
module dds_cmd_seq
    import dds_seq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int SYS_PER_MU = 3,
    parameter int WRITE_CYC  = 5,
    parameter int WRITE_MU   = 40,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [CH_W-1:0] cmd_chan,
    input  logic [31:0]     cmd_ftw,
    input  logic [62:0]     cmd_xftw,
    input  logic [15:0]     cmd_pow,
    input  logic [11:0]     cmd_asf,
    input  logic [1:0]      cmd_mode,
    input  logic [31:0]     cmd_start,
    input  logic [31:0]     cmd_ref,
    output logic            bus_wr,
    output logic [7:0]      bus_addr,
    output logic [15:0]     bus_data,
    output logic            busy,
    output logic            done,
    output logic [15:0]     res_pow
);
    cmd_t              q;
    logic [CH_W-1:0]   chan_q;
    logic              accept;
    logic              finish;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] num_writes;
    logic [15:0]       pow_word;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    // Capture the command fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            chan_q <= '0;
        end else if (accept) begin
            q.op      <= cmd_op;
            q.mode    <= cmd_mode;
            q.ftw     <= cmd_ftw;
            q.xftw    <= cmd_xftw;
            q.pow     <= cmd_pow;
            q.asf     <= cmd_asf;
            q.t_start <= cmd_start;
            q.t_ref   <= cmd_ref;
            chan_q    <= cmd_chan;
        end
    end

    dds_write_timer #(
        .WRITE_CYC (WRITE_CYC),
        .STEP_W    (STEP_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (accept),
        .num_writes (num_writes),
        .active     (busy),
        .step       (step),
        .strobe     (bus_wr),
        .finish     (finish)
    );

    dds_phase_comp #(
        .SYS_PER_MU (SYS_PER_MU),
        .WRITE_MU   (WRITE_MU)
    ) u_phase (
        .ftw     (q.ftw),
        .pow_in  (q.pow),
        .mode    (q.mode),
        .t_start (q.t_start),
        .t_ref   (q.t_ref),
        .pow_out (pow_word)
    );

    dds_seq_decode #(
        .CH_W (CH_W)
    ) u_decode (
        .op         (q.op),
        .mode       (q.mode),
        .chan       (chan_q),
        .ftw        (q.ftw),
        .xftw       (q.xftw),
        .pow_word   (pow_word),
        .asf        (q.asf),
        .step       (step),
        .num_writes (num_writes),
        .addr       (bus_addr),
        .data       (bus_data)
    );

    // Done pulse and returned phase word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            res_pow <= '0;
        end else begin
            done <= finish;
            if (finish && (q.op == OP_SET)) res_pow <= pow_word;
        end
    end
endmodule

// File: rtl/dds_cmd_seq_chk.sv
// Module: protocol checker for the DDS write sequencer, bound to the top.
// Measures the strobe spacing with a counter instead of a long delay.
module dds_cmd_seq_chk #(
    parameter int WRITE_CYC = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        busy,
    input logic        done,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [15:0] bus_data
);
    logic [15:0] gap;
    logic        armed;

    // Cycles since the last strobe of the running command.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (bus_wr) begin
            gap   <= 16'd1;
            armed <= 1'b1;
        end else begin
            gap <= gap + 16'd1;
        end
    end

    p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && armed |-> gap == 16'(WRITE_CYC));
    p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);
    p_strobe_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> busy);
    p_hold_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_wr |-> $stable(bus_addr) && $stable(bus_data));
    p_select_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bus_wr && bus_addr == 8'h81);
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    p_done_last_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_addr) == 8'h80 || $past(bus_addr) == 8'h1b));
endmodule

bind dds_cmd_seq dds_cmd_seq_chk #(.WRITE_CYC(WRITE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data)
);

// File: tb/dds_cmd_seq_tb.sv
// Bench: sweeps every channel and phase mode for standard sets, several
// extended words, both exit opcodes and a held-off second command.
module dds_cmd_seq_tb;
    localparam int NUM_CH = 8;
    localparam int CH_W   = 3;
    localparam int KMUL   = 3;
    localparam int WCYC   = 5;
    localparam int WMU    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [CH_W-1:0] cmd_chan = '0;
    logic [31:0] cmd_ftw = '0;
    logic [62:0] cmd_xftw = '0;
    logic [15:0] cmd_pow = '0;
    logic [11:0] cmd_asf = '0;
    logic [1:0] cmd_mode = '0;
    logic [31:0] cmd_start = '0;
    logic [31:0] cmd_ref = '0;
    logic bus_wr, busy, done;
    logic [7:0] bus_addr;
    logic [15:0] bus_data, res_pow;

    dds_cmd_seq #(.NUM_CH(NUM_CH), .SYS_PER_MU(KMUL), .WRITE_CYC(WCYC), .WRITE_MU(WMU)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_ftw(cmd_ftw), .cmd_xftw(cmd_xftw),
        .cmd_pow(cmd_pow), .cmd_asf(cmd_asf), .cmd_mode(cmd_mode),
        .cmd_start(cmd_start), .cmd_ref(cmd_ref), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_data(bus_data), .busy(busy), .done(done),
        .res_pow(res_pow));

    always #5 clk = ~clk;

    int vectors = 0, miscompares = 0;
    int cyc = 0, log_n = 0, done_cnt = 0, done_cyc = 0, ready_bad = 0;
    logic [7:0]  log_addr [0:15];
    logic [15:0] log_data [0:15];
    int          log_cyc  [0:15];
    logic [7:0]  exp_addr [0:6];
    logic [15:0] exp_data [0:6];
    string       exp_tag  [0:6];
    int          exp_n;
    logic [15:0] last_pow = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Record strobes, done pulses and ready-while-busy cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr) begin
                if (log_n < 16) begin
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_data;
                    log_cyc[log_n]  = cyc;
                end
                log_n++;
            end
            if (done) begin
                done_cyc = cyc;
                done_cnt++;
            end
            if (busy && cmd_ready) ready_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] exp_phase(input logic [15:0] p, input logic [31:0] f,
                                               input logic [1:0] m, input longint st, input longint rf);
        longint upd, dt, a, b, f64;
        logic [15:0] r;
        f64 = longint'({32'h0, f});
        upd = st + 6 * WMU;
        dt  = rf - upd;
        a   = dt * KMUL * f64;
        r   = p - a[31:16];
        if (m == 2'd2) begin
            b = rf * KMUL * f64;
            r = r + b[31:16];
        end
        return r;
    endfunction

    task automatic issue(input logic [1:0] op, input int ch, input logic [31:0] f,
                         input logic [62:0] x, input logic [15:0] p, input logic [11:0] a,
                         input logic [1:0] m, input longint st, input longint rf);
        @(negedge clk);
        cmd_op = op; cmd_chan = CH_W'(ch); cmd_ftw = f; cmd_xftw = x;
        cmd_pow = p; cmd_asf = a; cmd_mode = m;
        cmd_start = st[31:0]; cmd_ref = rf[31:0];
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic build(input logic [1:0] op, input int ch, input logic [31:0] f,
                         input logic [62:0] x, input logic [15:0] p, input logic [11:0] a,
                         input logic [1:0] m, input longint st, input longint rf);
        logic [15:0] sel;
        sel = 16'h0002 << ch;
        exp_addr[0] = 8'h81; exp_data[0] = sel; exp_tag[0] = "R3 select";
        if (op[1]) begin
            exp_n = 3;
            exp_addr[1] = 8'h19; exp_data[1] = 16'h0; exp_tag[1] = "R8 exit ramp lo";
            exp_addr[2] = 8'h1b; exp_data[2] = 16'h0; exp_tag[2] = "R8 exit ramp hi";
        end else if (op == 2'd1) begin
            exp_n = 7;
            exp_addr[1] = 8'h19; exp_data[1] = x[15:0];          exp_tag[1] = "R7 x ramp lo";
            exp_addr[2] = 8'h1b; exp_data[2] = {1'b0, x[30:16]}; exp_tag[2] = "R7 x ramp hi";
            exp_addr[3] = 8'h11; exp_data[3] = x[46:31];         exp_tag[3] = "R7 x freq lo";
            exp_addr[4] = 8'h13; exp_data[4] = x[62:47];         exp_tag[4] = "R7 x freq hi";
            exp_addr[5] = 8'h33; exp_data[5] = {4'h0, a};        exp_tag[5] = "R7 x ampl";
            exp_addr[6] = 8'h80; exp_data[6] = 16'h0;            exp_tag[6] = "R3 update";
        end else begin
            exp_n = 7;
            exp_addr[1] = 8'h11; exp_data[1] = f[15:0];   exp_tag[1] = "R2 freq lo";
            exp_addr[2] = 8'h13; exp_data[2] = f[31:16];  exp_tag[2] = "R2 freq hi";
            exp_addr[3] = 8'h01; exp_data[3] = (m == 2'd0) ? 16'h0108 : 16'h2108;
            exp_tag[3] = "R4 ctrl";
            exp_addr[4] = 8'h31; exp_data[4] = exp_phase(p, f, m, st, rf);
            exp_tag[4] = (m == 2'd2) ? "R6 phase track" : "R5 phase";
            exp_addr[5] = 8'h33; exp_data[5] = {4'h0, a}; exp_tag[5] = "R2 ampl";
            exp_addr[6] = 8'h80; exp_data[6] = 16'h0;     exp_tag[6] = "R3 update";
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input int ch, input logic [31:0] f,
                           input logic [62:0] x, input logic [15:0] p, input logic [11:0] a,
                           input logic [1:0] m, input longint st, input longint rf);
        int d0;
        build(op, ch, f, x, p, a, m, st, rf);
        log_n = 0;
        d0 = done_cnt;
        issue(op, ch, f, x, p, a, m, st, rf);
        while (done_cnt == d0) @(negedge clk);
        chk(log_n == exp_n, "R2 write count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_addr[i] == exp_addr[i], {exp_tag[i], " addr"}, log_addr[i], exp_addr[i]);
            chk(log_data[i] == exp_data[i], {exp_tag[i], " data"}, log_data[i], exp_data[i]);
            if (i > 0) chk(log_cyc[i] - log_cyc[i-1] == WCYC, "R1 slot spacing",
                           log_cyc[i] - log_cyc[i-1], WCYC);
        end
        if (log_n > 0)
            chk(done_cyc - log_cyc[log_n-1] == WCYC, "R10 done timing",
                done_cyc - log_cyc[log_n-1], WCYC);
        if (op == 2'd0) last_pow = exp_data[4];
        @(negedge clk);
        chk(res_pow == last_pow, "R10 res_pow", res_pow, last_pow);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R11 ready", cmd_ready, 1);
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(done == 1'b0, "R11 done", done, 0);
        chk(bus_wr == 1'b0, "R11 bus_wr", bus_wr, 0);
        chk(res_pow == 16'h0, "R11 res_pow", res_pow, 0);

        // Standard sets: every channel and mode, negative and positive offsets.
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int m = 0; m < 4; m++) begin
                longint st, rf;
                logic [31:0] f;
                st = (longint'(ch) << 36) + longint'(m) * 1000003 + 77;
                rf = st - 3000 + longint'(ch) * 5000 + longint'(m) * 333;
                f  = 32'h1234_5679 * 32'(ch + 1) + 32'h0101 * 32'(m) + 32'h8000_0000 * 32'(m & 1);
                run_cmd(2'd0, ch, f, 63'h0, 16'h1000 * 16'(m) + 16'(ch * 97),
                        12'hfff - 12'(ch * 17), 2'(m), st, rf);
            end
        end

        // Extended sets: res_pow must stay at the last standard-set value.
        run_cmd(2'd1, 0, 32'h0, 63'h7fff_ffff_ffff_ffff, 16'h0, 12'h123, 2'd0, 0, 0);
        run_cmd(2'd1, 7, 32'h0, 63'h0, 16'h0, 12'hfff, 2'd2, 0, 0);
        run_cmd(2'd1, 3, 32'h0, 63'h5555_5555_5555_5555, 16'h0, 12'h0, 2'd1, 0, 0);
        run_cmd(2'd1, 5, 32'h0, 63'h1234_5678_9abc_def0, 16'h0, 12'h800, 2'd0, 0, 0);

        // Extended exit through both opcodes.
        run_cmd(2'd2, 2, 32'h0, 63'h0, 16'h0, 12'h0, 2'd0, 0, 0);
        run_cmd(2'd3, 6, 32'hffff_ffff, 63'h7fff_ffff_ffff_ffff, 16'hffff, 12'hfff, 2'd3, 0, 0);

        // Hold-off: second command presented while the first runs (R9).
        begin
            int d0;
            log_n = 0;
            ready_bad = 0;
            d0 = done_cnt;
            issue(2'd0, 1, 32'hdead_beef, 63'h0, 16'h4321, 12'h0aa, 2'd0,
                  64'd500000, 64'd400000);
            issue(2'd2, 5, 32'h0, 63'h0, 16'h0, 12'h0, 2'd0, 0, 0);
            while (done_cnt < d0 + 2) @(negedge clk);
            chk(log_n == 10, "R9 held command total writes", log_n, 10);
            chk(ready_bad == 0, "R9 ready low while busy", ready_bad, 0);
            chk(log_addr[0] == 8'h81 && log_data[0] == 16'h0004, "R9 first select",
                log_data[0], 16'h0004);
            chk(log_data[1] == 16'hbeef, "R9 first freq lo intact", log_data[1], 16'hbeef);
            chk(log_data[2] == 16'hdead, "R9 first freq hi intact", log_data[2], 16'hdead);
            chk(log_addr[6] == 8'h80, "R9 first update", log_addr[6], 8'h80);
            chk(log_addr[7] == 8'h81 && log_data[7] == 16'h0040, "R9 second select",
                log_data[7], 16'h0040);
            chk(log_addr[8] == 8'h19 && log_addr[9] == 8'h1b, "R9 second exit writes",
                {log_addr[8], log_addr[9]}, 16'h191b);
            chk(log_cyc[7] - log_cyc[6] == WCYC + 1, "R9 accept in done cycle",
                log_cyc[7] - log_cyc[6], WCYC + 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule